// File: doc/BRIEF.md
# Sampled External Interrupt Request Unit

This block turns a small set of asynchronous, active-low interrupt pins into per-channel request flags for a microcontroller interrupt controller. Each pin passes through a two-stage synchroniser. A prescaler then samples it once per sampling cycle, which is six peripheral clocks long. A peripheral clock lasts two oscillator clocks in standard mode and one in double-speed mode. A per-channel mode bit selects one of two triggers: a low level seen at a sample, or a high sample followed by a low sample.

A detected event sets the channel's flag. The request line is the flag gated by an enable bit. When the controller acknowledges vectoring to an edge-mode channel, the flag clears in hardware. Level-mode flags stay set until software clears them through the write port. A detected event takes priority over a software clear or an acknowledge that lands in the same clock cycle. An internal synchroniser releases the asynchronous reset.

Top module: `ext_irq_sampler`

## Requirements
- R1: Write port field select `wr_sel`: 0 writes the mode bits, 1 the enable bits, 2 the flag bits, 3 has no effect. Bit i of `wr_data` belongs to channel i. Mode 0 means low-level trigger and mode 1 means falling-edge trigger.
- R2: `irq_o[i]` is high exactly when flag i and enable i are both set.
- R3: A detected event sets the flag, visible after the sampling edge. An event wins over a software flag write of 0 in the same cycle.
- R4: In edge mode, an acknowledge with `ack_valid` high and `ack_ch` equal to i clears flag i at that edge. An acknowledge naming a different channel leaves flag i unchanged.
- R5: In level mode, an acknowledge leaves the flag set. A software write of 0 clears it.
- R6: Sampling edges are the rising edges numbered 2+k*P after the rising edge of `rst_n` (k >= 1). P is 12 in standard mode and 6 when `x2_mode` is high. `x2_mode` may change only while `rst_n` is low. A low pulse that covers no sampled point is never flagged.
- R7: The value tested at a sampling edge is the pin level captured two rising edges earlier.
- R8: An edge event needs a high sample followed by a low sample. The previous sample resets to high. A low level spanning several samples gives exactly one event.
- R9: In level mode, a pin held low sets the flag again at each sampling edge, including after a software clear.
- R10: After reset, all flags, modes and enables are 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x2_mode | input | 1 | 1: one oscillator clock per peripheral clock; 0: two |
| pin_n | input | N_CH | Asynchronous active-low interrupt pins |
| wr_en | input | 1 | Write strobe for the configuration/flag port |
| wr_sel | input | 2 | Field select: 0 mode, 1 enable, 2 flag |
| wr_data | input | N_CH | Write data, one bit per channel |
| ack_valid | input | 1 | Controller is vectoring to channel `ack_ch` |
| ack_ch | input | CH_W | Acknowledged channel index |
| flag_o | output | N_CH | Request flags |
| irq_o | output | N_CH | Flags gated by enables |

## Verification
The in-line assertions check four things on every cycle. A detected event sets its flag on the next edge. An edge-mode acknowledge clears the flag, and a level-mode acknowledge keeps it. The flag never moves away from a sampling edge unless a write or an acknowledge is present. Sampling ticks never come back to back. Other behaviours only show up in the bench scenarios: the exact position of the first sampling edge in each clock mode, the two-cycle synchroniser offset, a short pulse slipping between sample points, a long edge-mode pulse giving one event, and an event beating a software clear.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_FLAG   = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;

  localparam int unsigned PCLKS_PER_SAMPLE = 6;
  localparam int unsigned OSC_PER_PCLK_STD = 2;
  localparam int unsigned SYNC_STAGES      = 2;
endpackage

// File: rtl/xirq_rst_sync.sv
module xirq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q, meta_d;
  logic hold_q, hold_d;

  always_comb begin
    meta_d = 1'b1;
    hold_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      hold_q <= hold_d;
    end
  end

  assign rst_n_sync = hold_q;
endmodule

// File: rtl/xirq_prescaler.sv
module xirq_prescaler #(
  parameter int unsigned PCLKS_PER_SAMPLE = 6,
  parameter int unsigned OSC_PER_PCLK_STD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x2_mode,
  output logic sample_tick
);
  localparam int unsigned PD_W = (OSC_PER_PCLK_STD > 1) ? $clog2(OSC_PER_PCLK_STD) : 1;
  localparam int unsigned SC_W = (PCLKS_PER_SAMPLE > 1) ? $clog2(PCLKS_PER_SAMPLE) : 1;
  localparam logic [PD_W-1:0] PD_LAST = PD_W'(OSC_PER_PCLK_STD - 1);
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(PCLKS_PER_SAMPLE - 1);

  logic [PD_W-1:0] pdiv_q, pdiv_d;
  logic [SC_W-1:0] scnt_q, scnt_d;
  logic            pclk_en;

  always_comb begin
    pclk_en = x2_mode || (pdiv_q == PD_LAST);
    if (x2_mode || (pdiv_q == PD_LAST)) pdiv_d = '0;
    else                                pdiv_d = pdiv_q + 1'b1;
    scnt_d = scnt_q;
    if (pclk_en) begin
      if (scnt_q == SC_LAST) scnt_d = '0;
      else                   scnt_d = scnt_q + 1'b1;
    end
    sample_tick = pclk_en && (scnt_q == SC_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdiv_q <= '0;
      scnt_q <= '0;
    end else begin
      pdiv_q <= pdiv_d;
      scnt_q <= scnt_d;
    end
  end

  // R6: a sampling cycle spans several clocks, so ticks never come back to back
  assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);

  // R6: the sub-cycle counter stays inside its range
  assert_scnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scnt_q <= SC_LAST);
endmodule

// File: rtl/xirq_pin_sync.sv
module xirq_pin_sync #(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] pin_n,
  output logic [N_CH-1:0] pin_s
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [STAGES-1:0] chain_q, chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], pin_n[c]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign pin_s[c] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/xirq_channel.sv
module xirq_channel (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_tick,
  input  logic pin_s,
  input  logic mode_wr,
  input  logic enable_wr,
  input  logic flag_wr,
  input  logic wdata,
  input  logic ack_hit,
  output logic mode_q,
  output logic enable_q,
  output logic flag_q
);
  logic prev_q, prev_d;
  logic mode_d, enable_d, flag_d;
  logic event_hit;

  always_comb begin
    event_hit = sample_tick && !pin_s && (mode_q ? prev_q : 1'b1);
    prev_d    = sample_tick ? pin_s : prev_q;
    mode_d    = mode_wr   ? wdata : mode_q;
    enable_d  = enable_wr ? wdata : enable_q;
    flag_d    = flag_q;
    if (flag_wr)           flag_d = wdata;
    if (ack_hit && mode_q) flag_d = 1'b0;
    if (event_hit)         flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b1;
      mode_q   <= 1'b0;
      enable_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      mode_q   <= mode_d;
      enable_q <= enable_d;
      flag_q   <= flag_d;
    end
  end

  // R3: a detected event always leaves the flag set
  assert_event_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    event_hit |=> flag_q);

  // R4: an edge-mode acknowledge without a competing event clears the flag
  assert_edge_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && mode_q && !event_hit) |=> !flag_q);

  // R5: a level-mode acknowledge leaves a set flag alone
  assert_level_ack_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !mode_q && flag_q && !flag_wr) |=> flag_q);

  // R6: away from sampling edges only writes and acknowledges move the flag
  assert_flag_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_tick && !flag_wr && !ack_hit) |=> $stable(flag_q));

  // R8: after an edge event the stored sample is low, so no second event follows
  assert_edge_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (event_hit && mode_q) |=> !prev_q);
endmodule

// File: rtl/ext_irq_sampler.sv
module ext_irq_sampler #(
  parameter int unsigned N_CH = 2,
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            x2_mode,
  input  logic [N_CH-1:0] pin_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [N_CH-1:0] wr_data,
  input  logic            ack_valid,
  input  logic [CH_W-1:0] ack_ch,
  output logic [N_CH-1:0] flag_o,
  output logic [N_CH-1:0] irq_o
);
  import xirq_pkg::*;

  logic            rst_n_i;
  logic            sample_tick;
  logic [N_CH-1:0] pin_s;
  logic [N_CH-1:0] mode_q, enable_q, flag_q;
  logic            sel_mode, sel_enable, sel_flag;

  always_comb begin
    sel_mode   = wr_en && (wr_sel_e'(wr_sel) == SEL_MODE);
    sel_enable = wr_en && (wr_sel_e'(wr_sel) == SEL_ENABLE);
    sel_flag   = wr_en && (wr_sel_e'(wr_sel) == SEL_FLAG);
  end

  xirq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  xirq_prescaler #(
    .PCLKS_PER_SAMPLE (PCLKS_PER_SAMPLE),
    .OSC_PER_PCLK_STD (OSC_PER_PCLK_STD)
  ) u_presc (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .x2_mode     (x2_mode),
    .sample_tick (sample_tick)
  );

  xirq_pin_sync #(
    .N_CH   (N_CH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .pin_n (pin_n),
    .pin_s (pin_s)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    logic ack_hit;
    assign ack_hit = ack_valid && (ack_ch == CH_W'(c));

    xirq_channel u_chan (
      .clk         (clk),
      .rst_n       (rst_n_i),
      .sample_tick (sample_tick),
      .pin_s       (pin_s[c]),
      .mode_wr     (sel_mode),
      .enable_wr   (sel_enable),
      .flag_wr     (sel_flag),
      .wdata       (wr_data[c]),
      .ack_hit     (ack_hit),
      .mode_q      (mode_q[c]),
      .enable_q    (enable_q[c]),
      .flag_q      (flag_q[c])
    );
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & enable_q;

  // R2: a request can only appear once its flag has been set
  assert_irq_after_flag_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(irq_o[0]) |-> $past(flag_q[0]) || flag_q[0]);
endmodule

// File: tb/ext_irq_sampler_test.sv
module ext_irq_sampler_test;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           x2_mode;
  logic [NCH-1:0] pin_n;
  logic           wr_en;
  logic [1:0]     wr_sel;
  logic [NCH-1:0] wr_data;
  logic           ack_valid;
  logic [0:0]     ack_ch;
  logic [NCH-1:0] flag_o, irq_o;

  int checks = 0;
  int errors = 0;

  // reference state
  int             n_edge;
  logic [NCH-1:0] m_mode, m_en, m_flag, m_prev, h1, h2;

  ext_irq_sampler #(.N_CH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .x2_mode(x2_mode), .pin_n(pin_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ack_valid(ack_valid), .ack_ch(ack_ch), .flag_o(flag_o), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  function automatic int period();
    return x2_mode ? 6 : 12;
  endfunction

  function automatic bit is_tick(int e);
    return (e > 2) && (((e - 2) % period()) == 0);
  endfunction

  function automatic int next_tick(int after);
    int e = after + 1;
    while (!is_tick(e)) e++;
    return e;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    int e = n_edge + 1;
    logic [NCH-1:0] nf;
    if (e > 2) begin
      nf = m_flag;
      for (int c = 0; c < NCH; c++) begin
        bit ev;
        ev = is_tick(e) && !h2[c] && (m_mode[c] ? m_prev[c] : 1'b1);
        if (wr_en && wr_sel == 2'd2) nf[c] = wr_data[c];
        if (ack_valid && ack_ch == 1'(c) && m_mode[c]) nf[c] = 1'b0;
        if (ev) nf[c] = 1'b1;
      end
      if (is_tick(e)) m_prev = h2;
      m_flag = nf;
      if (wr_en && wr_sel == 2'd0) m_mode = wr_data;
      if (wr_en && wr_sel == 2'd1) m_en = wr_data;
      h2 = h1;
      h1 = pin_n;
    end
    n_edge = e;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R3 flag vs reference", 32'(flag_o), 32'(m_flag));
    chk("R2 irq vs reference", 32'(irq_o), 32'(m_flag & m_en));
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; ack_valid = 1'b0; ack_ch = '0;
  endtask

  task automatic do_reset(logic x2, logic [NCH-1:0] pins);
    @(negedge clk);
    rst_n = 1'b0; x2_mode = x2; pin_n = pins; idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_edge = 0; m_mode = '0; m_en = '0; m_flag = '0; m_prev = '1; h1 = '1; h2 = '1;
  endtask

  task automatic wr(logic [1:0] sel, logic [NCH-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    idle();
  endtask

  task automatic ack(int c);
    ack_valid = 1'b1; ack_ch = 1'(c);
    step();
    idle();
  endtask

  // advance so that the next driven inputs are seen at edge e
  task automatic go_before(int e);
    while (n_edge < e - 1) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t, rises;
    logic last;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; x2_mode = 1'b0; pin_n = '1; idle();

    // R10 and R6: standard mode, pin 0 low from reset, level mode by default
    do_reset(1'b0, 2'b10);
    chk("R10 flags after reset", 32'(flag_o), 0);
    chk("R10 irq after reset", 32'(irq_o), 0);
    go_before(14);
    chk("R6 no flag before first standard sample", 32'(flag_o[0]), 0);
    step();
    chk("R6 flag at edge 14 standard", 32'(flag_o[0]), 1);
    chk("R2 irq masked while disabled", 32'(irq_o[0]), 0);
    wr(2'd1, 2'b01);
    chk("R2 irq with enable", 32'(irq_o[0]), 1);
    wr(2'd3, 2'b00);
    chk("R1 select 3 has no effect", 32'(irq_o), 1);

    // R5: level ack keeps, software clears
    ack(0);
    chk("R5 level ack keeps flag", 32'(flag_o[0]), 1);
    pin_n = 2'b11;
    repeat (30) step();
    wr(2'd2, 2'b00);
    chk("R5 software clear", 32'(flag_o[0]), 0);

    // R9: held low re-sets after clear
    pin_n = 2'b10;
    t = next_tick(n_edge + 3);
    go_before(t);
    step();
    chk("R9 level sets", 32'(flag_o[0]), 1);
    step();
    wr(2'd2, 2'b00);
    chk("R9 clear off tick", 32'(flag_o[0]), 0);
    t = next_tick(n_edge);
    go_before(t);
    step();
    chk("R9 level sets again", 32'(flag_o[0]), 1);

    // R3: event beats a same-cycle software clear
    t = next_tick(n_edge);
    go_before(t);
    wr(2'd2, 2'b00);
    chk("R3 event wins over clear", 32'(flag_o[0]), 1);

    // R4 and R8: edge mode on channel 1, long pulse spanning two samples
    pin_n = 2'b11;
    repeat (30) step();
    wr(2'd2, 2'b00);
    wr(2'd0, 2'b10);
    wr(2'd1, 2'b11);
    pin_n = 2'b01;
    rises = 0; last = flag_o[1];
    for (int k = 0; k < 40; k++) begin
      step();
      if (flag_o[1] && !last) begin
        rises++;
        ack(0);
        chk("R4 other channel ack keeps flag", 32'(flag_o[1]), 1);
        ack(1);
        chk("R4 edge ack clears", 32'(flag_o[1]), 0);
      end
      last = flag_o[1];
    end
    chk("R8 long pulse flagged once", 32'(rises), 1);
    chk("R8 no second edge event", 32'(flag_o[1]), 0);

    // R6: short pulse between sample points, both modes
    pin_n = 2'b11;
    repeat (30) step();
    wr(2'd2, 2'b00);
    t = next_tick(n_edge + 3);
    go_before(t - 1);
    pin_n = 2'b00;
    repeat (4) step();
    pin_n = 2'b11;
    repeat (14) step();
    chk("R6 short pulse ignored", 32'(flag_o), 0);

    // R6: first sample in double-speed mode
    do_reset(1'b1, 2'b10);
    go_before(8);
    chk("R6 no flag before edge 8 x2", 32'(flag_o[0]), 0);
    step();
    chk("R6 flag at edge 8 x2", 32'(flag_o[0]), 1);

    // R7: synchroniser offset
    pin_n = 2'b11;
    repeat (20) step();
    wr(2'd2, 2'b00);
    t = next_tick(n_edge + 4);
    go_before(t - 2);
    pin_n = 2'b01;
    step();
    pin_n = 2'b00;
    go_before(t + 1);
    chk("R7 pin captured 2 edges before sample", 32'(flag_o[1]), 1);
    chk("R7 pin captured 1 edge before sample", 32'(flag_o[0]), 0);
    go_before(t + 7);
    chk("R7 late pin seen at next sample", 32'(flag_o[0]), 1);

    // R8: previous sample resets high
    do_reset(1'b0, 2'b00);
    go_before(3);
    wr(2'd0, 2'b11);
    go_before(15);
    chk("R8 first low sample is an edge", 32'(flag_o), 3);
    ack(0);
    ack(1);
    repeat (30) step();
    chk("R8 steady low gives no new edge", 32'(flag_o), 0);

    // random phases
    for (int r = 0; r < 4; r++) begin
      do_reset(1'($urandom % 2), 2'b11);
      repeat (3000) begin
        if (($urandom % 16) == 0) pin_n[$urandom % 2] ^= 1'b1;
        if (($urandom % 10) == 0) begin
          wr_en = 1'b1; wr_sel = 2'($urandom % 4); wr_data = 2'($urandom);
        end
        if (($urandom % 8) == 0) begin
          ack_valid = 1'b1; ack_ch = 1'($urandom % 2);
        end
        step();
        idle();
      end
    end
    chk("R1 random phase completed", 32'(n_edge), 3000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule